// File: doc/BRIEF.md
# Delay-Line Tap Tracker with Rollover Checkstop

This block is the digital controller of a delay-locked loop. It keeps a tap index into a 128-stage delay chain and moves it one stage up or down per phase-detector decision. The analog chain is outside the block; it receives the tap select and a slow-mode select, which lengthens the delay of every stage for slower memory clocks.

The controller watches for wraparound of the index. Sitting on the top tap is treated as a potential rollover, because one more up-step would land on tap 0. An actual wrap in either direction is also caught. When detection is armed, either condition latches a checkstop for the processor. Detection can be armed while the loop first seeks lock, or later once lock is held. A warning flags operation within a couple of stages of either end of the chain.

The index is also offered as a read-only status field. A stable-read helper compares the last two status samples so that a reader can accept only a value that has held still.

Top module: `dll_tap_tracker`

## Requirements
- R1: After reset, tap_o is 64, chkstop_o is 0, near_edge_o is 0, status_o is 64, status_stable_o is 1 and slow_o is 0.
- R2: With en_i high, an up_i pulse alone raises tap_o by one at the next clock edge, and a dn_i pulse alone lowers it by one.
- R3: With en_i high, up_i and dn_i together, or neither, leave tap_o unchanged.
- R4: While en_i is low, tap_o goes to 64 at the next edge, and up_i and dn_i have no effect.
- R5: An up-step from tap 127 gives tap 0, and a down-step from tap 0 gives tap 127.
- R6: With rov_det_en_i and en_i high, a cycle in which tap_o is 127 sets chkstop_o at the next edge, whether or not a wrap follows.
- R7: With rov_det_en_i and en_i high, a down-step from tap 0 sets chkstop_o at the same edge that wraps the tap to 127.
- R8: chkstop_o stays high until rst_ni is asserted, whatever the loop does; with rov_det_en_i low it is never set, even at tap 127 or through a wrap.
- R9: near_edge_o is high exactly when tap_o is 2 or less, or 125 or more.
- R10: status_o equals the tap_o of the previous cycle; status_stable_o is high when status_o equals the status value of the cycle before it.
- R11: slow_o follows slow_i one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Loop enable; low parks the tap at the midpoint |
| up_i | input | 1 | Phase detector asks for one more stage of delay |
| dn_i | input | 1 | Phase detector asks for one less stage of delay |
| rov_det_en_i | input | 1 | Arms rollover detection |
| slow_i | input | 1 | Requests the longer per-stage delay |
| tap_o | output | 7 | Selected delay stage, 0 to 127 |
| slow_o | output | 1 | Registered slow-mode select to the delay chain |
| chkstop_o | output | 1 | Sticky checkstop on potential or actual rollover |
| near_edge_o | output | 1 | Tap within two stages of either end |
| status_o | output | 7 | Read-only status copy of the tap |
| status_stable_o | output | 1 | Last two status samples agree |

## Verification
The bench walks the tap all the way down to 0 and up to 127 with detection off, so a design that checks the wrong band edge for the warning, or that saturates instead of wrapping, shows a wrong tap or warning at one precise step. A down-wrap from 0 with detection armed tests the actual-rollover path on its own; a design that only watches the top tap would leave the checkstop low. Parking at 127 with detection armed and no further pulse tests the potential case, and disabling the loop afterwards catches a checkstop that is not sticky. Simultaneous up and down pulses would move a design that lets one direction win, and pulses while disabled would move a design that does not park.

// File: rtl/dll_tap_pkg.sv
package dll_tap_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2,
    STEP_PARK = 2'd3
  } step_e;

  function automatic step_e decode_step(input logic en, input logic up, input logic dn);
    if (!en)            return STEP_PARK;
    else if (up && !dn) return STEP_UP;
    else if (dn && !up) return STEP_DN;
    else                return STEP_HOLD;
  endfunction

endpackage

// File: rtl/dll_tap_counter.sv
module dll_tap_counter
  import dll_tap_pkg::*;
#(
  parameter int TAP_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  step_e            step_i,
  output logic [TAP_W-1:0] tap_o
);
  localparam int NTAPS = 1 << TAP_W;
  localparam logic [TAP_W-1:0] MID = TAP_W'(NTAPS / 2);
  localparam logic [TAP_W-1:0] MAX = TAP_W'(NTAPS - 1);

  logic [TAP_W-1:0] cnt_q, cnt_d;

  // modular arithmetic gives the wrap in both directions
  always_comb begin
    unique case (step_i)
      STEP_UP:   cnt_d = cnt_q + TAP_W'(1);
      STEP_DN:   cnt_d = cnt_q - TAP_W'(1);
      STEP_PARK: cnt_d = MID;
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= MID;
    else         cnt_q <= cnt_d;
  end

  assign tap_o = cnt_q;

  a_r2_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && up_i && !dn_i && cnt_q != MAX) |=> (cnt_q == $past(cnt_q) + TAP_W'(1)));

  a_r2_step_dn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && dn_i && !up_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - TAP_W'(1)));

  a_r3_cancel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && up_i == dn_i) |=> $stable(cnt_q));

  a_r4_park_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == MID));

  a_r5_wrap_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && up_i && !dn_i && cnt_q == MAX) |=> (cnt_q == '0));

  a_r5_wrap_dn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && dn_i && !up_i && cnt_q == '0) |=> (cnt_q == MAX));

endmodule

// File: rtl/dll_rollover_mon.sv
module dll_rollover_mon
  import dll_tap_pkg::*;
#(
  parameter int TAP_W     = 7,
  parameter int EDGE_BAND = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAP_W-1:0] tap_i,
  input  step_e            step_i,
  input  logic             det_en_i,
  output logic             chkstop_o,
  output logic             near_edge_o
);
  localparam int NTAPS = 1 << TAP_W;
  localparam logic [TAP_W-1:0] MAX  = TAP_W'(NTAPS - 1);
  localparam logic [TAP_W-1:0] LO_B = TAP_W'(EDGE_BAND);
  localparam logic [TAP_W-1:0] HI_B = TAP_W'(NTAPS - 1 - EDGE_BAND);

  logic active, at_top, wrap_dn, chk_q;

  assign active  = (step_i != STEP_PARK);
  assign at_top  = (tap_i == MAX);                     // potential; also covers up-wrap
  assign wrap_dn = (step_i == STEP_DN) && (tap_i == '0); // actual down-wrap

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     chk_q <= 1'b0;
    else if (det_en_i && active && (at_top || wrap_dn)) chk_q <= 1'b1;
  end

  assign chkstop_o   = chk_q;
  assign near_edge_o = (tap_i <= LO_B) || (tap_i >= HI_B);

  a_r6_potential: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_en_i && active && tap_i == MAX) |=> chk_q);

  a_r7_actual_dn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_en_i && step_i == STEP_DN && tap_i == '0) |=> chk_q);

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_q |=> chk_q);

  a_r8_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chk_q && !det_en_i) |=> !chk_q);

endmodule

// File: rtl/dll_status_rd.sv
module dll_status_rd #(
  parameter int TAP_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAP_W-1:0] tap_i,
  output logic [TAP_W-1:0] status_o,
  output logic             stable_o
);
  localparam logic [TAP_W-1:0] MID = TAP_W'((1 << TAP_W) / 2);

  logic [TAP_W-1:0] cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= MID;
      prev_q <= MID;
    end else begin
      cur_q  <= tap_i;
      prev_q <= cur_q;
    end
  end

  assign status_o = cur_q;
  assign stable_o = (cur_q == prev_q);

  a_r10_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cur_q == $past(tap_i)));

endmodule

// File: rtl/dll_tap_tracker.sv
module dll_tap_tracker
  import dll_tap_pkg::*;
#(
  parameter int TAP_W     = 7,
  parameter int EDGE_BAND = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             rov_det_en_i,
  input  logic             slow_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             slow_o,
  output logic             chkstop_o,
  output logic             near_edge_o,
  output logic [TAP_W-1:0] status_o,
  output logic             status_stable_o
);
  step_e            step;
  logic [TAP_W-1:0] tap;
  logic             slow_q;

  assign step = decode_step(en_i, up_i, dn_i);

  dll_tap_counter #(.TAP_W(TAP_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .up_i   (up_i),
    .dn_i   (dn_i),
    .step_i (step),
    .tap_o  (tap)
  );

  dll_rollover_mon #(.TAP_W(TAP_W), .EDGE_BAND(EDGE_BAND)) u_mon (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tap_i       (tap),
    .step_i      (step),
    .det_en_i    (rov_det_en_i),
    .chkstop_o   (chkstop_o),
    .near_edge_o (near_edge_o)
  );

  dll_status_rd #(.TAP_W(TAP_W)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tap_i    (tap),
    .status_o (status_o),
    .stable_o (status_stable_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slow_q <= 1'b0;
    else         slow_q <= slow_i;
  end

  assign tap_o  = tap;
  assign slow_o = slow_q;

  a_r11_slow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (slow_q == $past(slow_i)));

endmodule

// File: tb/dll_tap_tracker_test.sv
module dll_tap_tracker_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0, up_i = 1'b0, dn_i = 1'b0, rov_det_en_i = 1'b0, slow_i = 1'b0;
  logic [6:0] tap_o, status_o;
  logic       slow_o, chkstop_o, near_edge_o, status_stable_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  dll_tap_tracker uut (
    .clk_i, .rst_ni, .en_i, .up_i, .dn_i, .rov_det_en_i, .slow_i,
    .tap_o, .slow_o, .chkstop_o, .near_edge_o, .status_o, .status_stable_o
  );

  typedef struct {
    logic [6:0] tap;
    logic       chk;
    logic       near;
    logic [6:0] stat;
    logic       stable;
    logic       slow;
    string      tag;
  } exp_t;

  exp_t q[$];

  // reference model state
  int m_cnt = 64, m_stat = 64, m_prev = 64;
  bit m_chk = 0, m_slow = 0;

  function automatic bit near_of(int t);
    return (t <= 2) || (t >= 125);
  endfunction

  task automatic chk_one(string tag, string what, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit en, bit up, bit dn, bit rov, bit slow, string tag);
    exp_t e;
    int   n;
    @(negedge clk_i);
    en_i = en; up_i = up; dn_i = dn; rov_det_en_i = rov; slow_i = slow;
    if (rov && en && (m_cnt == 127 || (dn && !up && m_cnt == 0))) m_chk = 1;
    if (!en)           n = 64;
    else if (up && !dn) n = (m_cnt + 1) % 128;
    else if (dn && !up) n = (m_cnt + 127) % 128;
    else               n = m_cnt;
    m_prev = m_stat;
    m_stat = m_cnt;
    m_cnt  = n;
    m_slow = slow;
    e.tap = 7'(m_cnt); e.chk = m_chk; e.near = near_of(m_cnt);
    e.stat = 7'(m_stat); e.stable = (m_stat == m_prev); e.slow = m_slow; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: pops one expected item per clock after the edge
  always @(posedge clk_i) begin
    if (q.size() != 0) begin
      exp_t e;
      #1;
      e = q.pop_front();
      tests++;
      chk_one(e.tag, "tap", tap_o, e.tap);
      chk_one(e.tag, "chkstop R6/R7/R8", chkstop_o, e.chk);
      chk_one(e.tag, "near_edge R9", near_edge_o, e.near);
      chk_one(e.tag, "status R10", status_o, e.stat);
      chk_one(e.tag, "stable R10", status_stable_o, e.stable);
      chk_one(e.tag, "slow R11", slow_o, e.slow);
    end
  end

  task automatic do_reset();
    wait (q.size() == 0);
    @(negedge clk_i);
    en_i = 0; up_i = 0; dn_i = 0; rov_det_en_i = 0; slow_i = 0;
    rst_ni = 0;
    m_cnt = 64; m_stat = 64; m_prev = 64; m_chk = 0; m_slow = 0;
    #9;
    @(negedge clk_i);
    rst_ni = 1;
    // R1: reset state seen at the ports
    tests++;
    chk_one("R1", "tap", tap_o, 64);
    chk_one("R1", "chkstop", chkstop_o, 0);
    chk_one("R1", "near_edge", near_edge_o, 0);
    chk_one("R1", "status", status_o, 64);
    chk_one("R1", "stable", status_stable_o, 1);
    chk_one("R1", "slow", slow_o, 0);
  endtask

  initial begin
    do_reset();
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0, "R2 up");
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, "R2 down");
    step(1, 1, 1, 0, 0, "R3 both");
    step(1, 1, 1, 0, 1, "R3 both");
    step(1, 0, 0, 0, 1, "R3 none");
    step(1, 0, 0, 0, 0, "R10 stable");
    step(0, 1, 0, 0, 0, "R4 park up");
    step(0, 0, 1, 0, 0, "R4 park dn");
    // descend to 0 with detection off, watching the warning band
    for (int i = 0; i < 64; i++) step(1, 0, 1, 0, 0, "R9 descend");
    step(1, 0, 1, 0, 0, "R5 wrap dn unarmed R8");
    step(1, 1, 0, 0, 0, "R5 wrap up unarmed R8");
    step(1, 0, 0, 1, 0, "R7 armed hold at 0");
    step(1, 0, 1, 1, 0, "R7 armed dn wrap");
    step(0, 0, 0, 0, 0, "R8 sticky park");
    step(1, 0, 0, 0, 0, "R8 sticky");
    do_reset();
    for (int i = 0; i < 63; i++) step(1, 1, 0, 0, 0, "R9 ascend");
    step(1, 0, 0, 0, 0, "R8 unarmed at top");
    step(1, 0, 0, 1, 0, "R6 potential");
    step(1, 0, 0, 0, 0, "R8 sticky");
    step(1, 0, 1, 0, 0, "R8 sticky");
    step(0, 0, 0, 0, 1, "R8 sticky park R11");
    step(1, 0, 0, 0, 0, "R10 stable");
    wait (q.size() == 0);
    @(negedge clk_i);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule